// File: doc/BRIEF.md
# Beam-Tagged Write Trace Buffer

This block records processor write transactions for debug into an on-chip circular trace memory. Each captured write produces a record holding four fields: the current scanline number, the colour-clock position within that scanline, the write address cut down to its low 13 bits, and the data byte. The scanline and colour-clock values are taken from the video beam counters on the same clock edge as the write strobe, so every record carries the beam position at the moment of the write.

Capture is off after reset. Software turns it on or off by loading a one-bit enable register. A clear pulse empties the buffer and is meant to be issued once per video frame. The buffer never blocks. When it is full, each new capture evicts the oldest record, so the most recent history is always kept. Stored records are read through a non-destructive indexed port. Index 0 is the oldest record and higher indices are newer. Read data appears one clock after the index is presented.

Top module: `beam_write_tracer`

## Requirements
- R1: After reset the occupancy count is 0 and the enable register is 0, so no write is captured until the enable register is loaded with 1.
- R2: A write strobe is captured only when the enable register value in that cycle is 1. Loading the enable register with `cfg_we_i` takes effect from the next cycle. While capture is off, writes leave the count and the stored records unchanged.
- R3: A captured record holds `line_i`, `cclk_i`, bits 12:0 of `wr_addr_i` and `wr_data_i`, all sampled on the capture edge. Address bits 15:13 are discarded.
- R4: Each capture that is not accompanied by a clear raises the count by one, up to a maximum of 4096. The count never exceeds 4096 and never wraps.
- R5: A capture that arrives when 4096 records are held discards the oldest record and stores the new one. The count stays at 4096.
- R6: Presenting index k with k < count returns, one clock later, the k-th oldest record (k = 0 is the oldest) and sets `rd_valid_o` to 1. If k >= count, `rd_valid_o` is 0. Reading never changes the contents or the count.
- R7: A clear pulse with no capture in the same cycle sets the count to 0 on the next clock.
- R8: When a clear and a capture occur in the same cycle, the clear is applied first. Afterwards the buffer holds exactly one record, which is the new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Load strobe for the enable register |
| cfg_en_i | input | 1 | Value loaded into the enable register |
| clear_i | input | 1 | Empties the buffer |
| wr_valid_i | input | 1 | Processor write strobe |
| wr_addr_i | input | 16 | Write address; only bits 12:0 are kept |
| wr_data_i | input | 8 | Write data |
| line_i | input | 16 | Current scanline |
| cclk_i | input | 16 | Current colour clock within the scanline |
| rd_idx_i | input | 12 | Record index counted from the oldest record |
| count_o | output | 13 | Number of records held (0..4096) |
| rd_valid_o | output | 1 | Previous cycle's index was below the count |
| rd_line_o | output | 16 | Scanline field of the record read |
| rd_cclk_o | output | 16 | Colour-clock field of the record read |
| rd_addr_o | output | 13 | Address field of the record read |
| rd_data_o | output | 8 | Data field of the record read |

## Verification
The assertions check the count on every cycle:
- it never passes 4096;
- it stays at 4096 under overflow;
- it holds when nothing is captured or cleared;
- it drops to zero or one after a clear;
- it always matches the distance between the write and oldest pointers.

Some behaviours can only be shown by the bench scenarios against its queue model. These are:
- the order of records after wrap-around;
- the loss of exactly the oldest record on overflow;
- the address masking;
- that the enable register gates capture;
- the content of the single record left after a clear that coincides with a capture.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
  localparam int unsigned LINE_W = 16;
  localparam int unsigned CCLK_W = 16;
  localparam int unsigned ADDR_W = 13;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic [CCLK_W-1:0] cclk;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } trace_rec_t;

  localparam int unsigned REC_W = $bits(trace_rec_t);
endpackage

// File: rtl/bwt_ram.sv
module bwt_ram #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned WIDTH = 53,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read-first: a same-address write is seen on the following read
  always_ff @(posedge clk_i) begin
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/bwt_ptr_ctrl.sv
module bwt_ptr_ctrl #(
  parameter int unsigned DEPTH = 4096,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             clear_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output logic             we_o,
  output logic [PTR_W-1:0] waddr_o,
  output logic [PTR_W-1:0] raddr_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FULL   = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] head_q, tail_q, head_d, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full;
  logic [PTR_W:0]   rsum;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  assign full = (cnt_q == FULL);

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (clear_i) begin
      head_d = cap_i ? ptr_inc('0) : '0;
      tail_d = '0;
      cnt_d  = cap_i ? CNT_W'(1) : '0;
    end else if (cap_i) begin
      head_d = ptr_inc(head_q);
      if (full) tail_d = ptr_inc(tail_q);
      else      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign we_o    = cap_i;
  assign waddr_o = clear_i ? '0 : head_q;

  always_comb begin
    rsum = {1'b0, tail_q} + {1'b0, rd_idx_i};
    if (rsum >= (PTR_W+1)'(DEPTH)) rsum = rsum - (PTR_W+1)'(DEPTH);
  end
  assign raddr_o = rsum[PTR_W-1:0];
  assign count_o = cnt_q;

  AST_CNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL); // R4
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && cap_i && !clear_i) |=> (cnt_q == FULL)); // R5
  AST_PTR_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PTR_W'(head_q - tail_q) == PTR_W'(cnt_q))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !clear_i) |=> $stable(cnt_q)); // R2
  AST_CLR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !cap_i) |=> (cnt_q == '0)); // R7
  AST_CLR_CAP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && cap_i) |=> (cnt_q == CNT_W'(1))); // R8
endmodule

// File: rtl/beam_write_tracer.sv
module beam_write_tracer
  import bwt_pkg::*;
#(
  parameter int unsigned DEPTH = 4096,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_en_i,
  input  logic              clear_i,
  input  logic              wr_valid_i,
  input  logic [BUS_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [CCLK_W-1:0] cclk_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              rd_valid_o,
  output logic [LINE_W-1:0] rd_line_o,
  output logic [CCLK_W-1:0] rd_cclk_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic             en_q, cap, we, rd_valid_q;
  logic [PTR_W-1:0] waddr, raddr;
  logic [CNT_W-1:0] cnt;
  trace_rec_t       wrec, rrec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b0;
    else if (cfg_we_i) en_q <= cfg_en_i;
  end

  assign cap = en_q & wr_valid_i;

  always_comb begin
    wrec.line = line_i;
    wrec.cclk = cclk_i;
    wrec.addr = wr_addr_i[ADDR_W-1:0];
    wrec.data = wr_data_i;
  end

  bwt_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .clear_i (clear_i),
    .rd_idx_i(rd_idx_i),
    .we_o    (we),
    .waddr_o (waddr),
    .raddr_o (raddr),
    .count_o (cnt)
  );

  bwt_ram #(.DEPTH(DEPTH), .WIDTH(REC_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wrec),
    .raddr_i(raddr),
    .rdata_o(rrec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_valid_q <= 1'b0;
    else         rd_valid_q <= ({1'b0, rd_idx_i} < (PTR_W+1)'(cnt));
  end

  assign count_o    = cnt;
  assign rd_valid_o = rd_valid_q;
  assign rd_line_o  = rrec.line;
  assign rd_cclk_o  = rrec.cclk;
  assign rd_addr_o  = rrec.addr;
  assign rd_data_o  = rrec.data;

  AST_OFF_NO_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !clear_i) |=> $stable(cnt)); // R2
  AST_EMPTY_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0) |=> !rd_valid_q); // R6
endmodule

// File: tb/beam_write_tracer_tb.sv
`timescale 1ns/1ps
module beam_write_tracer_tb;
  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 0, cfg_en = 0, clear = 0, wr_valid = 0;
  logic [15:0] wr_addr = 0, line = 0, cclk = 0;
  logic [7:0]  wr_data = 0;
  logic [11:0] rd_idx = 0;
  logic [12:0] count;
  logic        rd_valid;
  logic [15:0] rd_line, rd_cclk;
  logic [12:0] rd_addr;
  logic [7:0]  rd_data;

  int checks = 0, fails = 0;
  logic [52:0] q[$];
  bit          m_en = 0;
  bit          exp_valid;
  logic [52:0] exp_rec;
  string       tag = "R1";

  always #4 clk = ~clk;

  beam_write_tracer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_en_i(cfg_en),
    .clear_i(clear), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .line_i(line), .cclk_i(cclk), .rd_idx_i(rd_idx),
    .count_o(count), .rd_valid_o(rd_valid), .rd_line_o(rd_line),
    .rd_cclk_o(rd_cclk), .rd_addr_o(rd_addr), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // Model step before the edge, compare after it.
  task automatic step();
    exp_valid = rd_idx < q.size();
    if (exp_valid) exp_rec = q[rd_idx];
    if (clear) q.delete();
    if (m_en && wr_valid) begin
      if (q.size() == DEPTH) void'(q.pop_front());
      q.push_back({line, cclk, wr_addr[12:0], wr_data});
    end
    if (cfg_we) m_en = cfg_en;
    @(posedge clk); #1;
    chk(count == 13'(q.size()), {tag, " count"}, count, q.size());
    chk(rd_valid == exp_valid, "R6 rd_valid", rd_valid, exp_valid);
    if (exp_valid)
      chk({rd_line, rd_cclk, rd_addr, rd_data} == exp_rec, {tag, " R6 record"},
          {rd_line, rd_cclk, rd_addr, rd_data}, exp_rec);
    @(negedge clk);
    cfg_we = 0; clear = 0; wr_valid = 0;
  endtask

  task automatic rand_wr(input int pct);
    wr_valid = ($urandom_range(99) < pct);
    wr_addr  = 16'($urandom);
    wr_data  = 8'($urandom);
    line     = 16'($urandom);
    cclk     = 16'($urandom);
    rd_idx   = (q.size() > 0 && $urandom_range(3) != 0) ?
               12'($urandom_range(q.size() - 1)) : 12'($urandom);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(count == 0, "R1 reset count", count, 0);
    chk(rd_valid == 0, "R1 reset rd_valid", rd_valid, 0);

    tag = "R2";  // writes while disabled are dropped
    for (int i = 0; i < 20; i++) begin rand_wr(100); step(); end
    chk(count == 0, "R1 R2 capture off after reset", count, 0);

    cfg_we = 1; cfg_en = 1; wr_valid = 1; step();  // enable not yet in effect
    chk(count == 0, "R2 enable one cycle late", count, 0);

    tag = "R3";
    wr_valid = 1; wr_addr = 16'hFFFF; wr_data = 8'hA5; line = 16'h0123; cclk = 16'h00E3;
    rd_idx = 0; step();
    rd_idx = 0; step();
    chk(rd_addr == 13'h1FFF, "R3 address masked", rd_addr, 13'h1FFF);
    chk(rd_line == 16'h0123 && rd_cclk == 16'h00E3, "R3 beam fields",
        {rd_line, rd_cclk}, {16'h0123, 16'h00E3});

    tag = "R4";
    for (int i = 0; i < 300; i++) begin rand_wr(60); step(); end

    tag = "R2";
    cfg_we = 1; cfg_en = 0; step();
    for (int i = 0; i < 30; i++) begin rand_wr(100); step(); end
    cfg_we = 1; cfg_en = 1; step();

    tag = "R5";
    for (int i = 0; i < DEPTH + 200; i++) begin rand_wr(95); step(); end
    chk(count == 13'(DEPTH), "R4 R5 saturated at capacity", count, DEPTH);
    for (int i = 0; i < 50; i++) begin
      rand_wr(100); rd_idx = 0; step();
    end
    rd_idx = 12'(DEPTH - 1); step();
    chk(rd_valid == 1, "R5 newest at top index", rd_valid, 1);

    tag = "R7";
    clear = 1; step();
    chk(count == 0, "R7 clear empties", count, 0);
    for (int i = 0; i < 40; i++) begin rand_wr(70); step(); end

    tag = "R8";
    clear = 1; wr_valid = 1; wr_addr = 16'h2ABC; wr_data = 8'h3C; line = 7; cclk = 9;
    rd_idx = 0; step();
    chk(count == 1, "R8 clear+capture leaves one", count, 1);
    rd_idx = 0; step();
    chk(rd_data == 8'h3C && rd_addr == 13'h0ABC, "R8 surviving record",
        {rd_addr, rd_data}, {13'h0ABC, 8'h3C});
    rd_idx = 1; step();
    chk(rd_valid == 0, "R6 index past count", rd_valid, 0);

    tag = "R6";
    for (int i = 0; i < 500; i++) begin rand_wr(40); step(); end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule